// File: doc/BRIEF.md
# Per-Page Access Hotness Classifier

This block decides, for each of a small set of tracked physical pages, which memory-protection mode the encryption path should apply. Pages that are accessed often are classed hot and use counter-mode protection. Pages that are accessed rarely are classed cold and use the tweakable block mode, which needs no per-line metadata. Each access strobe raises a 6-bit saturating counter for its page. When a page crosses a threshold, the block issues a one-cycle transition request that carries the page number and the target mode. It does not touch any ciphertext itself.

The thresholds are tuned at run time. The block counts lookups in the counter-metadata cache over fixed epochs and compares the epoch hit rate with a target. When the rate is below the target, promotion is made harder. When the rate meets the target, promotion is made easier. At every epoch boundary all page counters are halved, so that old activity fades. A page with an open transition is frozen until the re-encryption side returns a done pulse for it.

Top module: `page_hotness_classifier`

## Requirements
- R1: After reset every page is cold (`page_mode` all 0), no request is pending, `promote_thr` is 16 and `demote_thr` is 8.
- R2: Each access raises its page's 6-bit counter by one, and the counter saturates at 63 rather than wrapping.
- R3: An access to a cold page whose incremented count is at or above `promote_thr` produces, on the next clock edge, `xreq_valid` high for exactly one cycle with `xreq_page` equal to the page and `xreq_to_ctr` = 1, and sets `page_mode` for that page to 1. Encoding: 1 = counter mode (hot), 0 = tweakable block mode (cold).
- R4: A round-robin scan visits page (k mod 16) at the k-th clock edge after reset release, counting from k = 0. A hot page whose count is below `demote_thr` gets a request with `xreq_to_ctr` = 0 at its visit, and its mode bit clears. A cold page whose count is at or above `promote_thr` is promoted the same way.
- R5: After a page raises a request it raises no further request until `done_valid` is pulsed with `done_page` equal to that page.
- R6: Every 1024 lookups (cycles with `meta_hit` or `meta_miss`) form an epoch. If hits × 100 < 95 × 1024, `promote_thr` rises by one. Otherwise it falls by one. The new value is visible after the edge that takes the last lookup.
- R7: `promote_thr` stays between 4 and 63, and `demote_thr` always equals `promote_thr` / 2, rounded down.
- R8: At an epoch boundary every counter is halved. An access in the same cycle is counted first. Its promotion test uses the incremented, unhalved count and the threshold in force before the update.
- R9: At most one request is issued per cycle. When an access-triggered promotion and a scan candidate coincide, the access wins, and the scan candidate is served on the scan's next visit to its page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Memory access strobe |
| acc_page | input | 4 | Page number of the access |
| meta_hit | input | 1 | Counter-metadata cache hit pulse |
| meta_miss | input | 1 | Counter-metadata cache miss pulse |
| done_valid | input | 1 | Re-encryption finished pulse |
| done_page | input | 4 | Page whose re-encryption finished |
| page_mode | output | 16 | Mode per page, 1 = counter mode, 0 = tweakable block mode |
| xreq_valid | output | 1 | Transition request strobe |
| xreq_page | output | 4 | Page of the transition request |
| xreq_to_ctr | output | 1 | Target mode of the request, 1 = counter mode |
| promote_thr | output | 6 | Current promotion threshold |
| demote_thr | output | 6 | Current demotion threshold |

## Verification
A corrupted page counter shows up as a promotion that comes one access too early or too late. It can also show up as a demotion that fires or fails to fire within 16 cycles of the epoch edge that exposes it. A stuck in-transition flag shows up as a page that never requests after its done pulse, or as a second request before the done pulse. A wrong hit tally or threshold register shows up on the threshold ports immediately after the epoch's last lookup. That is why the bench probes the 972 and 973 hit boundary and both clamps.

// File: rtl/phc_pkg.sv
package phc_pkg;
    typedef enum logic {
        MODE_TWEAK = 1'b0,
        MODE_CTR   = 1'b1
    } cipher_mode_e;
endpackage

// File: rtl/phc_cnt_next.sv
module phc_cnt_next #(
    parameter int CNT_W = 6
) (
    input  logic [CNT_W-1:0] cur_i,
    input  logic             inc_i,
    input  logic             halve_i,
    output logic [CNT_W-1:0] nxt_o
);
    localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};

    logic [CNT_W-1:0] bumped;

    always_comb begin
        bumped = (inc_i && cur_i != MAXV) ? cur_i + CNT_W'(1) : cur_i;
        // an access in a boundary cycle is counted before the decay
        nxt_o  = halve_i ? (bumped >> 1) : bumped;
    end
endmodule

// File: rtl/phc_thr_tuner.sv
module phc_thr_tuner #(
    parameter int EPOCH_LEN  = 1024,
    parameter int TARGET_PCT = 95,
    parameter int CNT_W      = 6,
    parameter int THR_INIT   = 16,
    parameter int THR_MIN    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit_i,
    input  logic             miss_i,
    output logic             epoch_end_o,
    output logic [CNT_W-1:0] promo_o,
    output logic [CNT_W-1:0] demo_o
);
    localparam int LK_W    = $clog2(EPOCH_LEN);
    localparam int HIT_W   = LK_W + 1;
    localparam int THR_MAX = (1 << CNT_W) - 1;
    localparam logic [31:0] GOAL = 32'(TARGET_PCT) * 32'(EPOCH_LEN);

    typedef struct packed {
        logic [LK_W-1:0]  lk;
        logic [HIT_W-1:0] hits;
        logic [CNT_W-1:0] promo;
    } tuner_t;

    tuner_t q, d;
    logic             lookup;
    logic [HIT_W-1:0] hit_total;

    always_comb begin
        d           = q;
        epoch_end_o = 1'b0;
        lookup      = hit_i | miss_i;
        hit_total   = q.hits + HIT_W'(hit_i);
        if (lookup) begin
            if (q.lk == LK_W'(EPOCH_LEN - 1)) begin
                epoch_end_o = 1'b1;
                d.lk        = '0;
                d.hits      = '0;
                if (32'(hit_total) * 32'd100 < GOAL) begin
                    if (q.promo != CNT_W'(THR_MAX)) d.promo = q.promo + CNT_W'(1);
                end else begin
                    if (q.promo > CNT_W'(THR_MIN)) d.promo = q.promo - CNT_W'(1);
                end
            end else begin
                d.lk   = q.lk + LK_W'(1);
                d.hits = hit_total;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.lk    <= '0;
            q.hits  <= '0;
            q.promo <= CNT_W'(THR_INIT);
        end else begin
            q <= d;
        end
    end

    assign promo_o = q.promo;
    assign demo_o  = q.promo >> 1;
endmodule

// File: rtl/phc_page_table.sv
module phc_page_table
    import phc_pkg::*;
#(
    parameter int NUM_PAGES = 16,
    parameter int CNT_W     = 6
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         acc_valid_i,
    input  logic [$clog2(NUM_PAGES)-1:0] acc_page_i,
    input  logic                         done_valid_i,
    input  logic [$clog2(NUM_PAGES)-1:0] done_page_i,
    input  logic                         epoch_end_i,
    input  logic [CNT_W-1:0]             promo_i,
    input  logic [CNT_W-1:0]             demo_i,
    output logic [NUM_PAGES-1:0]         mode_o,
    output logic                         req_valid_o,
    output logic [$clog2(NUM_PAGES)-1:0] req_page_o,
    output logic                         req_to_ctr_o
);
    localparam int PG_W = $clog2(NUM_PAGES);
    localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};

    typedef struct packed {
        logic [NUM_PAGES-1:0][CNT_W-1:0] cnt;
        logic [NUM_PAGES-1:0]            mode;
        logic [NUM_PAGES-1:0]            pend;
        logic [PG_W-1:0]                 ptr;
        logic                            req_v;
        logic [PG_W-1:0]                 req_pg;
        logic                            req_ctr;
    } table_t;

    table_t q, d;
    logic [NUM_PAGES-1:0][CNT_W-1:0] cnt_nxt;
    logic [CNT_W-1:0] acc_cur, acc_inc;
    logic             acc_fire, scan_up, scan_dn;
    logic [PG_W-1:0]  s;

    for (genvar g = 0; g < NUM_PAGES; g++) begin : g_ctr
        phc_cnt_next #(.CNT_W(CNT_W)) u_next (
            .cur_i   (q.cnt[g]),
            .inc_i   (acc_valid_i && (acc_page_i == PG_W'(g))),
            .halve_i (epoch_end_i),
            .nxt_o   (cnt_nxt[g])
        );
    end

    always_comb begin
        d       = q;
        d.req_v = 1'b0;
        d.cnt   = cnt_nxt;
        d.ptr   = (q.ptr == PG_W'(NUM_PAGES - 1)) ? '0 : q.ptr + PG_W'(1);

        if (done_valid_i) d.pend[done_page_i] = 1'b0;

        acc_cur  = q.cnt[acc_page_i];
        acc_inc  = (acc_cur == MAXV) ? acc_cur : acc_cur + CNT_W'(1);
        acc_fire = acc_valid_i && (q.mode[acc_page_i] == MODE_TWEAK) &&
                   !q.pend[acc_page_i] && (acc_inc >= promo_i);

        s       = q.ptr;
        scan_up = !q.pend[s] && (q.mode[s] == MODE_TWEAK) && (q.cnt[s] >= promo_i);
        scan_dn = !q.pend[s] && (q.mode[s] == MODE_CTR)   && (q.cnt[s] <  demo_i);

        if (acc_fire) begin
            d.req_v             = 1'b1;
            d.req_pg            = acc_page_i;
            d.req_ctr           = 1'b1;
            d.mode[acc_page_i]  = MODE_CTR;
            d.pend[acc_page_i]  = 1'b1;
        end else if (scan_up || scan_dn) begin
            d.req_v   = 1'b1;
            d.req_pg  = s;
            d.req_ctr = scan_up;
            d.mode[s] = scan_up ? MODE_CTR : MODE_TWEAK;
            d.pend[s] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign mode_o       = q.mode;
    assign req_valid_o  = q.req_v;
    assign req_page_o   = q.req_pg;
    assign req_to_ctr_o = q.req_ctr;
endmodule

// File: rtl/page_hotness_classifier.sv
module page_hotness_classifier #(
    parameter int NUM_PAGES  = 16,
    parameter int CNT_W      = 6,
    parameter int EPOCH_LEN  = 1024,
    parameter int TARGET_PCT = 95,
    parameter int THR_INIT   = 16,
    parameter int THR_MIN    = 4,
    localparam int PG_W      = $clog2(NUM_PAGES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 acc_valid,
    input  logic [PG_W-1:0]      acc_page,
    input  logic                 meta_hit,
    input  logic                 meta_miss,
    input  logic                 done_valid,
    input  logic [PG_W-1:0]      done_page,
    output logic [NUM_PAGES-1:0] page_mode,
    output logic                 xreq_valid,
    output logic [PG_W-1:0]      xreq_page,
    output logic                 xreq_to_ctr,
    output logic [CNT_W-1:0]     promote_thr,
    output logic [CNT_W-1:0]     demote_thr
);
    logic epoch_end;

    phc_thr_tuner #(
        .EPOCH_LEN  (EPOCH_LEN),
        .TARGET_PCT (TARGET_PCT),
        .CNT_W      (CNT_W),
        .THR_INIT   (THR_INIT),
        .THR_MIN    (THR_MIN)
    ) u_tuner (
        .clk         (clk),
        .rst_n       (rst_n),
        .hit_i       (meta_hit),
        .miss_i      (meta_miss),
        .epoch_end_o (epoch_end),
        .promo_o     (promote_thr),
        .demo_o      (demote_thr)
    );

    phc_page_table #(
        .NUM_PAGES (NUM_PAGES),
        .CNT_W     (CNT_W)
    ) u_table (
        .clk          (clk),
        .rst_n        (rst_n),
        .acc_valid_i  (acc_valid),
        .acc_page_i   (acc_page),
        .done_valid_i (done_valid),
        .done_page_i  (done_page),
        .epoch_end_i  (epoch_end),
        .promo_i      (promote_thr),
        .demo_i       (demote_thr),
        .mode_o       (page_mode),
        .req_valid_o  (xreq_valid),
        .req_page_o   (xreq_page),
        .req_to_ctr_o (xreq_to_ctr)
    );
endmodule

// File: rtl/phc_checker.sv
module phc_checker #(
    parameter int NUM_PAGES = 16,
    parameter int CNT_W     = 6,
    parameter int THR_MIN   = 4,
    localparam int PG_W     = $clog2(NUM_PAGES)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 done_valid,
    input logic [PG_W-1:0]      done_page,
    input logic [NUM_PAGES-1:0] page_mode,
    input logic                 xreq_valid,
    input logic [PG_W-1:0]      xreq_page,
    input logic                 xreq_to_ctr,
    input logic [CNT_W-1:0]     promote_thr,
    input logic [CNT_W-1:0]     demote_thr
);
    // R3: the mode bit of a requested page already shows the requested target
    assert_req_matches_mode_R3: assert property (@(posedge clk) disable iff (!rst_n)
        xreq_valid |-> (page_mode[xreq_page] == xreq_to_ctr));

    // R9: the mode vector only moves together with a request
    assert_mode_moves_with_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !xreq_valid |-> $stable(page_mode));

    // R9: no more than one page flips per cycle
    assert_single_flip_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(page_mode ^ $past(page_mode)) <= 1);

    // R5: a page never requests on two consecutive cycles
    assert_no_repeat_R5: assert property (@(posedge clk) disable iff (!rst_n)
        xreq_valid |=> !(xreq_valid && xreq_page == $past(xreq_page)));

    // R7: threshold pair stays in range
    assert_thr_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (promote_thr >= CNT_W'(THR_MIN)) && (demote_thr < promote_thr));

    // R6: thresholds move by at most one step per cycle
    assert_thr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (promote_thr == $past(promote_thr)) ||
        (promote_thr == $past(promote_thr) + CNT_W'(1)) ||
        (promote_thr + CNT_W'(1) == $past(promote_thr)));
endmodule

bind page_hotness_classifier phc_checker #(
    .NUM_PAGES (NUM_PAGES),
    .CNT_W     (CNT_W),
    .THR_MIN   (THR_MIN)
) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .done_valid  (done_valid),
    .done_page   (done_page),
    .page_mode   (page_mode),
    .xreq_valid  (xreq_valid),
    .xreq_page   (xreq_page),
    .xreq_to_ctr (xreq_to_ctr),
    .promote_thr (promote_thr),
    .demote_thr  (demote_thr)
);

// File: tb/test_page_hotness_classifier.sv
module test_page_hotness_classifier;
    localparam int EPOCH = 1024;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic [3:0]  acc_page = '0;
    logic        meta_hit = 1'b0;
    logic        meta_miss = 1'b0;
    logic        done_valid = 1'b0;
    logic [3:0]  done_page = '0;
    logic [15:0] page_mode;
    logic        xreq_valid;
    logic [3:0]  xreq_page;
    logic        xreq_to_ctr;
    logic [5:0]  promote_thr;
    logic [5:0]  demote_thr;

    int errs = 0;
    int checks = 0;
    int req_seen = 0;
    int cyc = 0;

    always #2 clk = ~clk;

    page_hotness_classifier i_page_hotness_classifier (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_page(acc_page),
        .meta_hit(meta_hit), .meta_miss(meta_miss), .done_valid(done_valid),
        .done_page(done_page), .page_mode(page_mode), .xreq_valid(xreq_valid),
        .xreq_page(xreq_page), .xreq_to_ctr(xreq_to_ctr),
        .promote_thr(promote_thr), .demote_thr(demote_thr)
    );

    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
        if (rst_n && xreq_valid) req_seen <= req_seen + 1;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic access_n(input int p, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); acc_valid = 1'b1; acc_page = 4'(p);
        end
        @(negedge clk); acc_valid = 1'b0;
    endtask

    task automatic pulse_done(input int p);
        @(negedge clk); done_valid = 1'b1; done_page = 4'(p);
        @(negedge clk); done_valid = 1'b0;
    endtask

    task automatic run_epoch(input int hits, input bit acc_last, input int p);
        for (int k = 0; k < EPOCH; k++) begin
            @(negedge clk);
            meta_hit  = (k < hits);
            meta_miss = !(k < hits);
            if (acc_last && k == EPOCH - 1) begin
                acc_valid = 1'b1; acc_page = 4'(p);
            end
        end
        @(negedge clk);
        meta_hit = 1'b0; meta_miss = 1'b0; acc_valid = 1'b0;
    endtask

    task automatic wait_req(input int limit);
        for (int i = 0; i < limit; i++) begin
            if (xreq_valid) break;
            @(negedge clk);
        end
    endtask

    task automatic t_reset;
        chk(page_mode == 16'h0, "R1", "page_mode", int'(page_mode), 0);
        chk(!xreq_valid, "R1", "xreq_valid", int'(xreq_valid), 0);
        chk(promote_thr == 6'd16, "R1", "promote_thr", int'(promote_thr), 16);
        chk(demote_thr == 6'd8, "R1", "demote_thr", int'(demote_thr), 8);
    endtask

    task automatic t_promote;
        access_n(3, 15);
        chk(!xreq_valid && !page_mode[3], "R3", "no request at 15", int'(xreq_valid), 0);
        access_n(3, 1);
        chk(xreq_valid && xreq_page == 4'd3 && xreq_to_ctr, "R3", "request page",
            int'(xreq_page), 3);
        chk(page_mode[3], "R3", "mode bit 3", int'(page_mode[3]), 1);
        @(negedge clk);
        chk(!xreq_valid, "R3", "one-cycle pulse", int'(xreq_valid), 0);
    endtask

    task automatic t_pending;
        int base;
        base = req_seen;
        run_epoch(0, 1'b0, 0);
        run_epoch(0, 1'b0, 0);
        chk(promote_thr == 6'd18, "R6", "promote after two low epochs", int'(promote_thr), 18);
        chk(demote_thr == 6'd9, "R7", "demote is half", int'(demote_thr), 9);
        repeat (20) @(negedge clk);
        chk(req_seen == base, "R5", "no request while pending", req_seen - base, 0);
        chk(page_mode[3], "R5", "page 3 held hot", int'(page_mode[3]), 1);
    endtask

    task automatic t_demote;
        pulse_done(3);
        wait_req(20);
        chk(xreq_valid && xreq_page == 4'd3, "R4", "demote page", int'(xreq_page), 3);
        chk(!xreq_to_ctr, "R4", "demote target", int'(xreq_to_ctr), 0);
        chk(!page_mode[3], "R4", "mode bit 3 cleared", int'(page_mode[3]), 0);
    endtask

    task automatic t_rate_edge;
        run_epoch(973, 1'b0, 0);
        chk(promote_thr == 6'd17, "R6", "973 hits lowers", int'(promote_thr), 17);
        run_epoch(972, 1'b0, 0);
        chk(promote_thr == 6'd18, "R6", "972 hits raises", int'(promote_thr), 18);
    endtask

    task automatic t_saturate;
        int base;
        access_n(5, 70);
        chk(page_mode[5], "R2", "page 5 promoted", int'(page_mode[5]), 1);
        pulse_done(5);
        @(negedge clk);
        base = req_seen;
        run_epoch(EPOCH, 1'b0, 0);
        chk(promote_thr == 6'd17, "R6", "full hits lowers", int'(promote_thr), 17);
        repeat (20) @(negedge clk);
        chk(page_mode[5], "R2", "saturated count keeps page hot", int'(page_mode[5]), 1);
        chk(req_seen == base, "R2", "no demotion request", req_seen - base, 0);
    endtask

    task automatic t_same_cycle;
        access_n(9, 16);
        chk(!xreq_valid && !page_mode[9], "R8", "page 9 below threshold", int'(page_mode[9]), 0);
        run_epoch(0, 1'b1, 9);
        chk(xreq_valid && xreq_page == 4'd9 && xreq_to_ctr, "R8",
            "access counted before halving", int'(xreq_valid), 1);
        chk(promote_thr == 6'd18, "R6", "threshold after epoch", int'(promote_thr), 18);
    endtask

    task automatic t_floor;
        for (int e = 0; e < 20; e++) run_epoch(EPOCH, 1'b0, 0);
        chk(promote_thr == 6'd4, "R7", "promote floor", int'(promote_thr), 4);
        chk(demote_thr == 6'd2, "R7", "demote at floor", int'(demote_thr), 2);
    endtask

    task automatic t_arbitrate;
        access_n(1, 3);
        chk(!xreq_valid && !page_mode[1], "R9", "page 1 primed", int'(page_mode[1]), 0);
        do @(negedge clk); while (cyc % 16 != 10);
        done_valid = 1'b1; done_page = 4'd9;
        @(negedge clk); done_valid = 1'b0;
        do @(negedge clk); while (cyc % 16 != 9);
        acc_valid = 1'b1; acc_page = 4'd1;
        @(negedge clk); acc_valid = 1'b0;
        chk(xreq_valid && xreq_page == 4'd1 && xreq_to_ctr, "R9", "access wins",
            int'(xreq_page), 1);
        @(negedge clk);
        wait_req(20);
        chk(xreq_valid && xreq_page == 4'd9 && !xreq_to_ctr, "R9", "scan candidate later",
            int'(xreq_page), 9);
        chk(!page_mode[9], "R4", "page 9 demoted", int'(page_mode[9]), 0);
    endtask

    task automatic t_ceiling;
        for (int e = 0; e < 62; e++) run_epoch(0, 1'b0, 0);
        chk(promote_thr == 6'd63, "R7", "promote ceiling", int'(promote_thr), 63);
        chk(demote_thr == 6'd31, "R7", "demote at ceiling", int'(demote_thr), 31);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_promote();
        t_pending();
        t_demote();
        t_rate_edge();
        t_saturate();
        t_same_cycle();
        t_floor();
        t_arbitrate();
        t_ceiling();
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errs++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule